// File: doc/BRIEF.md
# Watchdog Escalation Controller

This block sits behind a window classifier and decides how hard the system is punished for each bad watchdog service. Every service outcome arrives as one event on a valid/ready port. The event is one of four kinds: an OK service, an early service, a late service or a missing service. A late event also carries how many cycles it overshot the window. The controller raises its response in stages. A first or sparse violation gives a one-cycle interrupt request and puts the block in a degraded level. A burst of violations inside a cooldown window moves it to a limp (power-limit) level, which it leaves only after a run of healthy services. Two missing services in a row, or a late service that overshoots by more than a set threshold, start a reset sequence.

The reset sequence has a fixed order that never changes. First the controller asks an external evidence latch to capture the cause and waits for its acknowledge. Then it may send one interrupt request. Last it drives a reset pulse of programmable width. When the pulse ends, all decision state is cleared and the block is back at its normal level. While power-good is low, events are still taken but change nothing, so a rail drop cannot cause an escalation.

Top module: `wdog_escalate`

## Requirements
- R1: After reset, irq_req, degrade, limp, latch_req and rst_out are low and evt_ready is high.
- R2: evt_kind is encoded 00 OK, 01 early, 10 late, 11 missing. Each accepted violation that does not start a reset gives irq_req high for exactly the next cycle. From the normal level, such a violation moves the block to the degraded level (degrade high). The degraded level returns to normal when its cooldown window ends without a limp entry.
- R3: A cooldown window starts at the first violation seen while no window is open and lasts cfg_cool cycles (treated as 1 if zero). The cfg_k-th violation inside an open window moves the block to limp (limp high, degrade low) and restarts the window.
- R4: In limp, cfg_m OK events in a row return the block to normal. Any violation in between restarts that run.
- R5: The block enters limp at most once per cooldown window. After a limp exit, further violations in the same window reach only the degraded level.
- R6: A missing event directly after another accepted missing event, or a late event with evt_over strictly greater than cfg_hard_late, starts the reset sequence. latch_req is raised with latch_cause (10 for hard late, 11 for missing) and held until latch_ack. If cfg_irq_before_rst is set, irq_req is then high for one cycle. Only after that does rst_out rise. irq_req is never high while rst_out is high.
- R7: An event accepted while power_good is low has no effect on any output or on the decision state.
- R8: rst_out is high for exactly max(cfg_rst_width,1) cycles. After it falls, the block is at the normal level with its counters cleared.
- R9: evt_ready is low from the first cycle of latch_req to the end of rst_out. At other times events are accepted whenever evt_valid is high. A held event waits and is not lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| power_good | input | 1 | Rails valid; escalation allowed only when high |
| cfg_k | input | CNT_W | Violations per window that trigger limp |
| cfg_m | input | CNT_W | OK events in a row needed to leave limp |
| cfg_cool | input | COOL_W | Cooldown window length in cycles |
| cfg_hard_late | input | OVER_W | Overshoot beyond which a late event is hard |
| cfg_rst_width | input | PW_W | Reset pulse width in cycles |
| cfg_irq_before_rst | input | 1 | Insert one irq cycle between latch and reset |
| evt_valid | input | 1 | Event present |
| evt_ready | output | 1 | Event accepted when high with evt_valid |
| evt_kind | input | 2 | Event kind (00 OK, 01 early, 10 late, 11 missing) |
| evt_over | input | OVER_W | Late overshoot in cycles |
| latch_req | output | 1 | Request to evidence latch |
| latch_cause | output | 2 | Cause presented with latch_req |
| latch_ack | input | 1 | Evidence latch has captured |
| irq_req | output | 1 | Interrupt request pulse |
| degrade | output | 1 | Degraded (interrupt) level active |
| limp | output | 1 | Limp / power-limit level active |
| rst_out | output | 1 | Reset pulse |

## Verification
Every level output and the irq_req pulse are registered at the same edge that accepts the event, so each is due in the cycle right after acceptance. The bench drives at the falling edge and samples one nanosecond after the next rising edge. latch_req likewise appears one cycle after the triggering event. The optional interrupt and the first rst_out cycle each come one edge after the acknowledge is sampled, and the bench samples each of those cycles in turn. Reset width is measured by sampling rst_out in every cycle of a window wider than the pulse. The cooldown expiry is checked after an idle stretch longer than cfg_cool, so the exact edge of the expiry does not matter.

// File: rtl/wdesc_pkg.sv
package wdesc_pkg;
  typedef enum logic [1:0] {
    EV_OK      = 2'b00,
    EV_EARLY   = 2'b01,
    EV_LATE    = 2'b10,
    EV_MISSING = 2'b11
  } ev_kind_t;

  typedef enum logic [2:0] {
    ST_NORMAL,
    ST_IRQ,
    ST_LIMP,
    ST_LATCH,
    ST_PREIRQ,
    ST_RESET
  } esc_state_t;

  localparam logic [1:0] CAUSE_HARD_LATE = 2'b10;
  localparam logic [1:0] CAUSE_MISSING   = 2'b11;
endpackage

// File: rtl/wdesc_cooldown.sv
module wdesc_cooldown #(
  parameter int CNT_W  = 8,
  parameter int COOL_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              viol,
  input  logic              esc_set,
  input  logic [COOL_W-1:0] cfg_cool,
  output logic [CNT_W-1:0]  viol_nxt,
  output logic              esc_blk,
  output logic              expire
);
  localparam logic [CNT_W-1:0]  CNT_MAX = {CNT_W{1'b1}};
  localparam logic [COOL_W-1:0] ONE_C   = {{(COOL_W-1){1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0]  ONE_V   = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [COOL_W-1:0] cool_q;
  logic [CNT_W-1:0]  viol_q;
  logic              esc_q;
  logic              new_win;
  logic [COOL_W-1:0] cool_ld;

  assign cool_ld  = (cfg_cool == '0) ? ONE_C : cfg_cool;
  assign new_win  = (cool_q <= ONE_C);
  assign viol_nxt = new_win ? ONE_V : ((viol_q == CNT_MAX) ? viol_q : viol_q + ONE_V);
  assign esc_blk  = !new_win && esc_q;
  assign expire   = !viol && (cool_q == ONE_C);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cool_q <= '0;
      viol_q <= '0;
      esc_q  <= 1'b0;
    end else if (clear) begin
      cool_q <= '0;
      viol_q <= '0;
      esc_q  <= 1'b0;
    end else if (viol) begin
      viol_q <= viol_nxt;
      esc_q  <= esc_set || esc_blk;
      cool_q <= (new_win || esc_set) ? cool_ld : cool_q - ONE_C;
    end else if (cool_q != '0) begin
      cool_q <= cool_q - ONE_C;
      if (cool_q == ONE_C) begin
        viol_q <= '0;
        esc_q  <= 1'b0;
      end
    end
  end

  AST_WIN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (cool_q == '0) |-> (viol_q == '0 && !esc_q)); // R3
endmodule

// File: rtl/wdesc_rst_pulse.sv
module wdesc_rst_pulse #(
  parameter int PW_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [PW_W-1:0] cfg_width,
  output logic            active,
  output logic            done
);
  localparam logic [PW_W-1:0] ONE_P = {{(PW_W-1){1'b0}}, 1'b1};

  logic [PW_W-1:0] cnt_q;

  assign active = (cnt_q != '0);
  assign done   = (cnt_q == ONE_P);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (start)          cnt_q <= (cfg_width == '0) ? ONE_P : cfg_width;
    else if (cnt_q != '0)    cnt_q <= cnt_q - ONE_P;
  end

  AST_PULSE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !start) |=> !active); // R8
endmodule

// File: rtl/wdog_escalate.sv
module wdog_escalate
  import wdesc_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int COOL_W = 16,
  parameter int OVER_W = 16,
  parameter int PW_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              power_good,
  input  logic [CNT_W-1:0]  cfg_k,
  input  logic [CNT_W-1:0]  cfg_m,
  input  logic [COOL_W-1:0] cfg_cool,
  input  logic [OVER_W-1:0] cfg_hard_late,
  input  logic [PW_W-1:0]   cfg_rst_width,
  input  logic              cfg_irq_before_rst,
  input  logic              evt_valid,
  output logic              evt_ready,
  input  logic [1:0]        evt_kind,
  input  logic [OVER_W-1:0] evt_over,
  output logic              latch_req,
  output logic [1:0]        latch_cause,
  input  logic              latch_ack,
  output logic              irq_req,
  output logic              degrade,
  output logic              limp,
  output logic              rst_out
);
  localparam int HW = CNT_W + 1;

  esc_state_t       st_q, st_d;
  ev_kind_t         kind;
  logic [CNT_W-1:0] healthy_q;
  logic [CNT_W-1:0] viol_nxt;
  logic [1:0]       cause_q;
  logic             miss_run_q, irq_q, ev_locked_q;
  logic             acc, act, is_viol, is_hard, is_cmiss;
  logic             go_rst, go_limp, esc_blk, cool_exp;
  logic             pulse_start, pulse_active, pulse_done, seq_clear;
  logic             healthy_full;

  assign kind      = ev_kind_t'(evt_kind);
  assign evt_ready = (st_q == ST_NORMAL) || (st_q == ST_IRQ) || (st_q == ST_LIMP);
  assign acc       = evt_valid && evt_ready;
  assign act       = acc && power_good;
  assign is_viol   = (kind != EV_OK);
  assign is_hard   = (kind == EV_LATE) && (evt_over > cfg_hard_late);
  assign is_cmiss  = (kind == EV_MISSING) && miss_run_q;
  assign go_rst    = act && (is_hard || is_cmiss);
  assign go_limp   = act && is_viol && !go_rst && (st_q != ST_LIMP)
                     && (viol_nxt >= cfg_k) && !esc_blk;
  assign healthy_full = ({1'b0, healthy_q} + HW'(1)) >= {1'b0, cfg_m};
  assign seq_clear    = (st_q == ST_RESET) && pulse_done;
  assign pulse_start  = ((st_q == ST_LATCH) && latch_ack && !cfg_irq_before_rst)
                        || (st_q == ST_PREIRQ);

  wdesc_cooldown #(.CNT_W(CNT_W), .COOL_W(COOL_W)) u_cool (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (seq_clear),
    .viol     (act && is_viol),
    .esc_set  (go_limp),
    .cfg_cool (cfg_cool),
    .viol_nxt (viol_nxt),
    .esc_blk  (esc_blk),
    .expire   (cool_exp)
  );

  wdesc_rst_pulse #(.PW_W(PW_W)) u_pulse (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (pulse_start),
    .cfg_width (cfg_rst_width),
    .active    (pulse_active),
    .done      (pulse_done)
  );

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_NORMAL, ST_IRQ: begin
        if (go_rst)                           st_d = ST_LATCH;
        else if (go_limp)                     st_d = ST_LIMP;
        else if (act && is_viol)              st_d = ST_IRQ;
        else if (st_q == ST_IRQ && cool_exp)  st_d = ST_NORMAL;
      end
      ST_LIMP: begin
        if (go_rst)                                 st_d = ST_LATCH;
        else if (act && !is_viol && healthy_full)   st_d = ST_NORMAL;
      end
      ST_LATCH:  if (latch_ack) st_d = cfg_irq_before_rst ? ST_PREIRQ : ST_RESET;
      ST_PREIRQ: st_d = ST_RESET;
      ST_RESET:  if (pulse_done) st_d = ST_NORMAL;
      default:   st_d = ST_NORMAL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_NORMAL;
      healthy_q   <= '0;
      miss_run_q  <= 1'b0;
      irq_q       <= 1'b0;
      cause_q     <= 2'b00;
      ev_locked_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      irq_q <= act && is_viol && !go_rst;
      if (go_rst) cause_q <= is_hard ? CAUSE_HARD_LATE : CAUSE_MISSING;
      if (seq_clear)                             ev_locked_q <= 1'b0;
      else if (st_q == ST_LATCH && latch_ack)    ev_locked_q <= 1'b1;
      if (seq_clear)  miss_run_q <= 1'b0;
      else if (act)   miss_run_q <= (kind == EV_MISSING);
      if (st_q != ST_LIMP)      healthy_q <= '0;
      else if (act && is_viol)  healthy_q <= '0;
      else if (act)             healthy_q <= healthy_q + CNT_W'(1);
    end
  end

  assign irq_req     = irq_q || (st_q == ST_PREIRQ);
  assign degrade     = (st_q == ST_IRQ);
  assign limp        = (st_q == ST_LIMP);
  assign latch_req   = (st_q == ST_LATCH);
  assign latch_cause = cause_q;
  assign rst_out     = pulse_active;

  AST_RST_AFTER_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    rst_out |-> ev_locked_q); // R6
  AST_NO_IRQ_IN_RST: assert property (@(posedge clk) disable iff (!rst_n)
    rst_out |-> !irq_req); // R6
  AST_PG_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_ready && !power_good && !limp) |=> (!limp && !latch_req)); // R7
  AST_RST_IN_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_out |-> (st_q == ST_RESET)); // R8
  AST_READY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_req || rst_out) |-> !evt_ready); // R9
endmodule

// File: tb/wdog_escalate_bench.sv
module wdog_escalate_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        power_good = 1'b1;
  logic [7:0]  cfg_k = 8'd3, cfg_m = 8'd2, cfg_rst_width = 8'd4;
  logic [15:0] cfg_cool = 16'd40, cfg_hard_late = 16'd5;
  logic        cfg_irq_before_rst = 1'b1;
  logic        evt_valid = 1'b0, evt_ready;
  logic [1:0]  evt_kind = 2'b00;
  logic [15:0] evt_over = '0;
  logic        latch_req, latch_ack = 1'b0;
  logic [1:0]  latch_cause;
  logic        irq_req, degrade, limp, rst_out;
  int          n_chk = 0, n_bad = 0, n_rst;

  always #5 clk = ~clk;

  wdog_escalate u_wdog_escalate (
    .clk(clk), .rst_n(rst_n), .power_good(power_good),
    .cfg_k(cfg_k), .cfg_m(cfg_m), .cfg_cool(cfg_cool),
    .cfg_hard_late(cfg_hard_late), .cfg_rst_width(cfg_rst_width),
    .cfg_irq_before_rst(cfg_irq_before_rst),
    .evt_valid(evt_valid), .evt_ready(evt_ready), .evt_kind(evt_kind),
    .evt_over(evt_over), .latch_req(latch_req), .latch_cause(latch_cause),
    .latch_ack(latch_ack), .irq_req(irq_req), .degrade(degrade),
    .limp(limp), .rst_out(rst_out)
  );

  typedef struct packed {
    logic [1:0] kind;
    logic [7:0] over;
    logic       pg;
    logic [3:0] req;
    logic       irq;
    logic       deg;
    logic       lmp;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{2'd0, 8'd0, 1'b1, 4'd2, 1'b0, 1'b0, 1'b0},  // R2 OK at rest
    '{2'd1, 8'd0, 1'b1, 4'd2, 1'b1, 1'b1, 1'b0},  // R2 first early
    '{2'd0, 8'd0, 1'b1, 4'd2, 1'b0, 1'b1, 1'b0},  // R2 stays degraded
    '{2'd2, 8'd3, 1'b1, 4'd2, 1'b1, 1'b1, 1'b0},  // R2 soft late
    '{2'd1, 8'd0, 1'b0, 4'd7, 1'b0, 1'b1, 1'b0},  // R7 ignored without power
    '{2'd3, 8'd0, 1'b1, 4'd3, 1'b1, 1'b0, 1'b1},  // R3 third violation
    '{2'd0, 8'd0, 1'b1, 4'd4, 1'b0, 1'b0, 1'b1},  // R4 one healthy
    '{2'd0, 8'd0, 1'b1, 4'd4, 1'b0, 1'b0, 1'b0},  // R4 exit limp
    '{2'd1, 8'd0, 1'b1, 4'd5, 1'b1, 1'b1, 1'b0},  // R5 no second limp
    '{2'd1, 8'd0, 1'b1, 4'd5, 1'b1, 1'b1, 1'b0}   // R5 still blocked
  };

  task automatic chk(input string req, input string what, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic send(input logic [1:0] k, input logic [15:0] o, input logic pg);
    @(negedge clk);
    evt_valid = 1'b1; evt_kind = k; evt_over = o; power_good = pg;
    @(posedge clk); #1;
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    evt_valid = 1'b0; power_good = 1'b1;
    for (int i = 1; i < n; i++) @(negedge clk);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1", "irq", irq_req, 0);
    chk("R1", "degrade", degrade, 0);
    chk("R1", "limp", limp, 0);
    chk("R1", "latch_req", latch_req, 0);
    chk("R1", "rst_out", rst_out, 0);
    chk("R1", "ready", evt_ready, 1);

    for (int i = 0; i < 10; i++) begin
      send(VECS[i].kind, {8'd0, VECS[i].over}, VECS[i].pg);
      chk($sformatf("R%0d", VECS[i].req), "irq", irq_req, VECS[i].irq);
      chk($sformatf("R%0d", VECS[i].req), "degrade", degrade, VECS[i].deg);
      chk($sformatf("R%0d", VECS[i].req), "limp", limp, VECS[i].lmp);
      chk($sformatf("R%0d", VECS[i].req), "latch_req", latch_req, 0);
    end

    idle(45);
    @(posedge clk); #1;
    chk("R2", "degrade after cooldown", degrade, 0);

    send(2'd1, 16'd0, 1'b1);
    chk("R3", "new window degrade", degrade, 1);
    send(2'd1, 16'd0, 1'b1);
    send(2'd1, 16'd0, 1'b1);
    chk("R3", "limp on kth in new window", limp, 1);
    send(2'd3, 16'd0, 1'b1);
    chk("R2", "single missing irq", irq_req, 1);
    chk("R4", "limp held", limp, 1);
    send(2'd3, 16'd0, 1'b1);
    chk("R6", "latch on repeat missing", latch_req, 1);
    chk("R6", "cause missing", latch_cause, 3);
    chk("R6", "no irq at latch", irq_req, 0);
    chk("R9", "ready low at latch", evt_ready, 0);
    @(negedge clk); evt_valid = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #1;
      chk("R6", "latch held waiting ack", latch_req, 1);
      chk("R6", "no reset before ack", rst_out, 0);
    end
    @(negedge clk); latch_ack = 1'b1;
    @(posedge clk); #1;
    chk("R6", "irq between latch and reset", irq_req, 1);
    chk("R6", "reset not yet", rst_out, 0);
    chk("R6", "latch dropped", latch_req, 0);
    @(negedge clk); latch_ack = 1'b0;
    n_rst = 0;
    for (int i = 0; i < 8; i++) begin
      @(posedge clk); #1;
      if (rst_out) begin
        n_rst++;
        chk("R9", "ready low in reset", evt_ready, 0);
      end
    end
    chk("R8", "reset width 4", n_rst, 4);
    chk("R8", "limp cleared", limp, 0);
    chk("R8", "ready back", evt_ready, 1);

    @(negedge clk); cfg_irq_before_rst = 1'b0; cfg_rst_width = 8'd2;
    send(2'd2, 16'd5, 1'b1);
    chk("R6", "late at threshold not hard", latch_req, 0);
    chk("R2", "late at threshold irq", irq_req, 1);
    send(2'd2, 16'd6, 1'b0);
    chk("R7", "hard late without power", latch_req, 0);
    chk("R7", "no irq without power", irq_req, 0);
    send(2'd2, 16'd6, 1'b1);
    chk("R6", "hard late latch", latch_req, 1);
    chk("R6", "cause hard late", latch_cause, 2);
    @(negedge clk); evt_valid = 1'b0; latch_ack = 1'b1;
    @(posedge clk); #1;
    chk("R6", "reset directly after ack", rst_out, 1);
    chk("R6", "no irq when option off", irq_req, 0);
    @(negedge clk); latch_ack = 1'b0;
    n_rst = 1;
    for (int i = 0; i < 6; i++) begin
      @(posedge clk); #1;
      if (rst_out) n_rst++;
    end
    chk("R8", "reset width 2", n_rst, 2);
    chk("R8", "degrade cleared", degrade, 0);

    summary();
    $finish;
  end
endmodule